// File: doc/BRIEF.md
# Decimating Stream Repacketizer

The block accepts a stream of samples on a valid/ready interface, with a 128-bit routing header on a side-band user bus, and keeps every N-th accepted sample. The decimation factor N is a runtime input. The kept samples are framed again into output packets of a fixed length. Packet ends are set by the block's own count of emitted samples and not by the input packet boundaries. Each output packet carries a rewritten header: the old destination ID becomes the new source ID, and a next-destination input supplies the new destination ID.

The header comes from the most recent input beat, the one that brings in the first kept sample of each output packet. The block holds no queue of headers, one per input packet. That design would overflow when decimating, because several input packets fold into one output packet. The block suits continuous sample streams with no timing sensitivity. Filtering, timestamp correction and end-of-burst handling stay outside it.

Top module: `dsr_decim_repack`

## Requirements
- R1: Input samples are counted from reset, starting at zero. Of each group of N accepted samples, only the last one is forwarded: the samples with index N-1, 2N-1 and so on. The data is forwarded unchanged, and each emitted sample appears exactly once and in order.
- R2: The decimation phase keeps running across input packet ends, so input packet lengths need not be a multiple of N. Input `in_tlast` has no effect on which samples are kept or on where output packets end.
- R3: `out_tlast` is high on every PKT_LEN-th emitted sample (default 364). After that sample the count starts again at zero.
- R4: The output header is built from the input header `h` as follows. Bits 127:96 are `h[127:96]`. Bits 95:80 are `h[79:64]`. Bits 79:64 are `next_dst`. Bits 63:0 are `h[63:0]`. Both `h` and `next_dst` are taken in the cycle that accepts the first kept sample of the output packet.
- R5: `out_tuser` stays constant from the first sample of an output packet until the handshake of that packet's `out_tlast` beat.
- R6: `decim_factor` is sampled during reset and again in the cycle of each `out_tlast` handshake. A sample accepted in that same cycle already uses the new value. A change made in the middle of a packet has no effect until then. A factor of 0 acts as 1.
- R7: `in_tready` is low only when `out_tvalid` is high and `out_tready` is low.
- R8: While `out_tvalid` is high and `out_tready` is low, `out_tvalid`, `out_tdata` and `out_tuser` hold their values.
- R9: A synchronous reset discards any pending output sample and clears the decimation phase and the packet count. In the cycle after reset, `out_tvalid` is low and `in_tready` is high.
- R10: With N = 1, every accepted input sample is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_tdata | input | DATA_W | Input sample |
| in_tvalid | input | 1 | Input sample valid |
| in_tready | output | 1 | Block can take an input sample |
| in_tlast | input | 1 | Input packet end (not used for framing) |
| in_tuser | input | 128 | Input routing header |
| out_tdata | output | DATA_W | Kept sample |
| out_tvalid | output | 1 | Output sample valid |
| out_tready | input | 1 | Downstream takes the output sample |
| out_tlast | output | 1 | Last sample of an output packet |
| out_tuser | output | 128 | Rewritten output header |
| next_dst | input | 16 | New destination ID for output headers |
| decim_factor | input | FACTOR_W | Keep one of this many samples |

## Verification
A phase counter that has slipped sends the wrong input sample to the output. The data compare catches this on the first kept sample after the fault, which is at most N accepted inputs later. An off-by-one in the packet count shows up as `out_tlast` on the wrong beat, within one output packet. A header latched at the wrong moment shows up on the first beat of the next packet, where `out_tuser` carries the wrong field values. A factor applied too early shows up as wrong kept data, because the bench changes the factor mid-packet. A pending sample that survives reset is reported in the cycle right after reset.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
   localparam int HDR_W      = 128;
   localparam int ID_W       = 16;
   localparam int KEEP_LO    = 96;  // bits above this pass through unchanged
   localparam int SRC_LO     = 80;  // new source ID field
   localparam int DST_LO     = 64;  // destination ID field
   typedef logic [HDR_W-1:0] hdr_t;
   typedef logic [ID_W-1:0]  id_t;
endpackage

// File: rtl/dsr_phase_ctr.sv
module dsr_phase_ctr #(
   parameter int FACTOR_W = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                step,
   input  logic [FACTOR_W-1:0] factor,
   output logic                keep
);
   logic [FACTOR_W-1:0] phase;
   logic [FACTOR_W-1:0] limit;

   // a factor of zero behaves as one
   assign limit = (factor == '0) ? '0 : factor - FACTOR_W'(1);
   assign keep  = step && (phase >= limit);

   always_ff @(posedge clk) begin
      if (rst)
         phase <= '0;
      else if (step)
         phase <= keep ? '0 : phase + FACTOR_W'(1);
   end
endmodule

// File: rtl/dsr_hdr_rewrite.sv
module dsr_hdr_rewrite
   import dsr_pkg::*;
#(
   parameter bit SWAP_IDS = 1'b1
) (
   input  hdr_t hdr_in,
   input  id_t  new_dst,
   output hdr_t hdr_out
);
   generate
      if (SWAP_IDS) begin : g_swap
         assign hdr_out = {hdr_in[HDR_W-1:KEEP_LO],
                           hdr_in[DST_LO+ID_W-1:DST_LO],
                           new_dst,
                           hdr_in[DST_LO-1:0]};
      end else begin : g_keep_src
         assign hdr_out = {hdr_in[HDR_W-1:SRC_LO],
                           new_dst,
                           hdr_in[DST_LO-1:0]};
      end
   endgenerate
endmodule

// File: rtl/dsr_out_framer.sv
module dsr_out_framer
   import dsr_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int PKT_LEN = 364
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  hdr_t              load_hdr,
   input  logic              out_tready,
   output logic              out_tvalid,
   output logic [DATA_W-1:0] out_tdata,
   output hdr_t              out_tuser,
   output logic              out_tlast,
   output logic              pkt_done,
   output logic              space
);
   localparam int CNT_W = (PKT_LEN > 1) ? $clog2(PKT_LEN) : 1;
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PKT_LEN - 1);

   logic [CNT_W-1:0] sent;   // samples handed off in the current packet
   logic             fire;
   logic             first_slot;

   assign fire      = out_tvalid && out_tready;
   assign out_tlast = (sent == LAST_IDX);
   assign pkt_done  = fire && out_tlast;
   assign space     = !out_tvalid || out_tready;
   // the incoming sample opens a packet when nothing of it has been emitted
   assign first_slot = fire ? out_tlast : (sent == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         out_tvalid <= 1'b0;
         sent       <= '0;
      end else begin
         if (fire)
            sent <= out_tlast ? '0 : sent + CNT_W'(1);
         if (load)
            out_tvalid <= 1'b1;
         else if (fire)
            out_tvalid <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (load) begin
         out_tdata <= load_data;
         if (first_slot)
            out_tuser <= load_hdr;
      end
   end
endmodule

// File: rtl/dsr_decim_repack.sv
module dsr_decim_repack
   import dsr_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int FACTOR_W = 8,
   parameter int PKT_LEN  = 364,
   parameter bit SWAP_IDS = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [DATA_W-1:0]   in_tdata,
   input  logic                in_tvalid,
   output logic                in_tready,
   input  logic                in_tlast,
   input  logic [127:0]        in_tuser,
   output logic [DATA_W-1:0]   out_tdata,
   output logic                out_tvalid,
   input  logic                out_tready,
   output logic                out_tlast,
   output logic [127:0]        out_tuser,
   input  logic [15:0]         next_dst,
   input  logic [FACTOR_W-1:0] decim_factor
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (FACTOR_W < 1 || FACTOR_W > 16) begin : g_bad_factor
         $error("FACTOR_W must lie in 1..16");
      end
      if (PKT_LEN < 1) begin : g_bad_len
         $error("PKT_LEN must be at least 1");
      end
   endgenerate

   logic                space;
   logic                step;
   logic                keep;
   logic                pkt_done;
   logic [FACTOR_W-1:0] factor_q;
   logic [FACTOR_W-1:0] factor_eff;
   hdr_t                new_hdr;
   logic                unused_last;

   assign unused_last = in_tlast;  // framing is driven by the output count only
   assign in_tready   = space;
   assign step        = in_tvalid && space;
   assign factor_eff  = pkt_done ? decim_factor : factor_q;

   always_ff @(posedge clk) begin
      if (rst || pkt_done)
         factor_q <= decim_factor;
   end

   dsr_phase_ctr #(.FACTOR_W(FACTOR_W)) u_phase (
      .clk    (clk),
      .rst    (rst),
      .step   (step),
      .factor (factor_eff),
      .keep   (keep)
   );

   dsr_hdr_rewrite #(.SWAP_IDS(SWAP_IDS)) u_hdr (
      .hdr_in  (in_tuser),
      .new_dst (next_dst),
      .hdr_out (new_hdr)
   );

   dsr_out_framer #(.DATA_W(DATA_W), .PKT_LEN(PKT_LEN)) u_framer (
      .clk        (clk),
      .rst        (rst),
      .load       (keep),
      .load_data  (in_tdata),
      .load_hdr   (new_hdr),
      .out_tready (out_tready),
      .out_tvalid (out_tvalid),
      .out_tdata  (out_tdata),
      .out_tuser  (out_tuser),
      .out_tlast  (out_tlast),
      .pkt_done   (pkt_done),
      .space      (space)
   );
endmodule

// File: rtl/dsr_decim_repack_chk.sv
module dsr_decim_repack_chk #(
   parameter int DATA_W  = 32,
   parameter int PKT_LEN = 364
) (
   input logic              clk,
   input logic              rst,
   input logic              in_tvalid,
   input logic              in_tready,
   input logic [DATA_W-1:0] out_tdata,
   input logic              out_tvalid,
   input logic              out_tready,
   input logic              out_tlast,
   input logic [127:0]      out_tuser
);
   int unsigned beats;

   always_ff @(posedge clk) begin
      if (rst)
         beats <= 0;
      else if (out_tvalid && out_tready)
         beats <= out_tlast ? 0 : beats + 1;
   end

   assert_fwd_after_input_R1: assert property (@(posedge clk) disable iff (rst)
      $rose(out_tvalid) |-> $past(in_tvalid && in_tready));

   assert_pkt_len_R3: assert property (@(posedge clk) disable iff (rst)
      (out_tvalid && out_tready) |-> (out_tlast == (beats == PKT_LEN - 1)));

   assert_hdr_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (out_tvalid && out_tready && !out_tlast) |=> $stable(out_tuser));

   assert_stall_only_R7: assert property (@(posedge clk) disable iff (rst)
      !in_tready |-> (out_tvalid && !out_tready));

   assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (out_tvalid && !out_tready) |=>
         (out_tvalid && $stable(out_tdata) && $stable(out_tuser)));

   assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !out_tvalid);
endmodule

bind dsr_decim_repack dsr_decim_repack_chk #(.DATA_W(DATA_W), .PKT_LEN(PKT_LEN)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .in_tvalid  (in_tvalid),
   .in_tready  (in_tready),
   .out_tdata  (out_tdata),
   .out_tvalid (out_tvalid),
   .out_tready (out_tready),
   .out_tlast  (out_tlast),
   .out_tuser  (out_tuser)
);

// File: tb/dsr_decim_repack_bench.sv
module dsr_decim_repack_bench;
   localparam int DATA_W   = 32;
   localparam int FACTOR_W = 8;
   localparam int PKT_LEN  = 364;

   typedef struct {
      logic [DATA_W-1:0] data;
      logic [127:0]      hdr;
   } exp_t;

   logic                clk = 1'b0;
   logic                rst = 1'b1;
   logic [DATA_W-1:0]   in_tdata = '0;
   logic                in_tvalid = 1'b0;
   logic                in_tready;
   logic                in_tlast = 1'b0;
   logic [127:0]        in_tuser = '0;
   logic [DATA_W-1:0]   out_tdata;
   logic                out_tvalid;
   logic                out_tready = 1'b1;
   logic                out_tlast;
   logic [127:0]        out_tuser;
   logic [15:0]         next_dst = 16'h0000;
   logic [FACTOR_W-1:0] decim_factor = 8'd1;

   int unsigned compared = 0;
   int unsigned mismatched = 0;
   int unsigned bp_pct = 0;
   string       cur_req = "R1";

   exp_t        q[$];
   int unsigned m_phase = 0;
   int unsigned m_cnt = 0;
   int unsigned m_n = 1;
   logic [127:0] m_pkt_hdr = '0;
   logic        prev_stall = 1'b0;
   logic [DATA_W-1:0] prev_data = '0;
   logic [DATA_W-1:0] seq = '0;

   always #10 clk = ~clk;  // 50 MHz

   dsr_decim_repack #(.DATA_W(DATA_W), .FACTOR_W(FACTOR_W), .PKT_LEN(PKT_LEN)) u_dsr_decim_repack (
      .clk, .rst, .in_tdata, .in_tvalid, .in_tready, .in_tlast, .in_tuser,
      .out_tdata, .out_tvalid, .out_tready, .out_tlast, .out_tuser,
      .next_dst, .decim_factor
   );

   function automatic logic [127:0] rewrite(logic [127:0] h, logic [15:0] nd);
      return {h[127:96], h[79:64], nd, h[63:0]};
   endfunction

   function automatic int unsigned clamp(logic [FACTOR_W-1:0] f);
      return (f == 0) ? 1 : int'(f);
   endfunction

   task automatic check(string req, logic [127:0] act, logic [127:0] exp, string what);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // reference model and port monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (rst) begin
         q.delete();
         m_phase = 0; m_cnt = 0; m_n = clamp(decim_factor);
         prev_stall = 1'b0;
      end else begin
         bit out_fire;
         bit pkt_end;
         int unsigned n_eff;
         out_fire = out_tvalid && out_tready;
         pkt_end  = 1'b0;
         if (prev_stall) begin
            check("R8", {127'b0, out_tvalid}, 128'd1, "valid held under stall");
            check("R8", 128'(out_tdata), 128'(prev_data), "data held under stall");
         end
         if ((in_tready == 1'b0) && !(out_tvalid && !out_tready))
            check("R7", {127'b0, in_tready}, 128'd1, "in_tready only low on stall");
         if (out_fire) begin
            if (q.size() == 0) begin
               check(cur_req, 128'(out_tdata), 128'hx, "unexpected output sample");
            end else begin
               exp_t e;
               e = q.pop_front();
               if (m_cnt == 0) m_pkt_hdr = e.hdr;
               check(cur_req, 128'(out_tdata), 128'(e.data), "kept sample");
               check("R3", {127'b0, out_tlast}, {127'b0, m_cnt == PKT_LEN - 1}, "tlast position");
               check("R4", out_tuser, m_pkt_hdr, "header / R5 held");
               pkt_end = (m_cnt == PKT_LEN - 1);
               m_cnt = pkt_end ? 0 : m_cnt + 1;
            end
         end
         n_eff = pkt_end ? clamp(decim_factor) : m_n;
         if (pkt_end) m_n = n_eff;
         if (in_tvalid && in_tready) begin
            if (m_phase + 1 >= n_eff) begin
               exp_t e;
               e.data = in_tdata;
               e.hdr  = rewrite(in_tuser, next_dst);
               q.push_back(e);
               m_phase = 0;
            end else begin
               m_phase++;
            end
         end
         prev_stall = out_tvalid && !out_tready;
         prev_data  = out_tdata;
      end
   end

   // downstream readiness from a fixed-seed random source
   always @(posedge clk) begin
      #1;
      if (bp_pct >= 100) out_tready = 1'b0;
      else out_tready = ($urandom % 100) >= bp_pct;
   end

   task automatic push_beat(bit last);
      bit ok;
      if ($urandom % 4 == 0) begin
         @(posedge clk); #1;
      end
      seq++;
      in_tdata  = seq;
      in_tuser  = {$urandom, $urandom, $urandom, $urandom};
      in_tlast  = last;
      in_tvalid = 1'b1;
      do begin
         @(negedge clk);
         ok = in_tready;
         @(posedge clk); #1;
      end while (!ok);
      in_tvalid = 1'b0;
      in_tlast  = 1'b0;
   endtask

   task automatic stream(int unsigned n, int unsigned max_in_len);
      int unsigned left = 1 + ($urandom % max_in_len);
      for (int unsigned i = 0; i < n; i++) begin
         left--;
         push_beat(left == 0);
         if (left == 0) left = 1 + ($urandom % max_in_len);
      end
   endtask

   task automatic drain();
      bp_pct = 0;
      repeat (20) @(posedge clk);
      #1;
      check(cur_req, 128'(q.size()), 128'd0, "samples left undelivered");
   endtask

   task automatic do_reset(logic [FACTOR_W-1:0] f);
      decim_factor = f;
      rst = 1'b1;
      repeat (2) @(posedge clk);
      #1 rst = 1'b0;
      seq = '0;
   endtask

   initial begin
      void'($urandom(32'h5eed_0d5e));
      #1;
      do_reset(8'd1);
      @(negedge clk);
      check("R9", {127'b0, out_tvalid}, 128'd0, "out_tvalid after reset");
      check("R9", {127'b0, in_tready}, 128'd1, "in_tready after reset");
      @(posedge clk); #1;

      // N = 1 passes every sample, no backpressure
      cur_req = "R10"; next_dst = 16'hA1B2;
      stream(PKT_LEN * 2 + 10, 40);
      drain();

      // N = 10 with random backpressure and random input packet lengths
      cur_req = "R1"; do_reset(8'd10); next_dst = 16'h0C0D; bp_pct = 40;
      stream(PKT_LEN * 10 * 2 + 37, 60);
      drain();

      // N = 3 with short, odd input packets: phase runs across input tlast
      cur_req = "R2"; do_reset(8'd3); next_dst = 16'h3333; bp_pct = 20;
      stream(PKT_LEN * 3 + 200, 7);
      drain();

      // factor changed mid-packet: old value holds until the packet ends
      cur_req = "R6"; do_reset(8'd4); next_dst = 16'h4444; bp_pct = 10;
      stream(300, 50);
      decim_factor = 8'd7;
      stream(PKT_LEN * 4 - 300 + PKT_LEN * 7 + 20, 50);
      drain();

      // factor 0 acts as 1
      cur_req = "R6"; do_reset(8'd0); next_dst = 16'h5555; bp_pct = 30;
      stream(PKT_LEN + 5, 30);
      drain();

      // reset while a kept sample is stalled
      cur_req = "R9"; do_reset(8'd1); bp_pct = 100;
      @(posedge clk); #1;
      push_beat(1'b0);
      @(negedge clk);
      check("R7", {127'b0, in_tready}, 128'd0, "in_tready low while pending");
      check("R8", {127'b0, out_tvalid}, 128'd1, "pending sample visible");
      @(posedge clk); #1;
      do_reset(8'd2);
      @(negedge clk);
      check("R9", {127'b0, out_tvalid}, 128'd0, "pending sample discarded");
      check("R9", {127'b0, in_tready}, 128'd1, "ready after reset");
      @(posedge clk); #1;
      bp_pct = 0;
      stream(PKT_LEN * 2 + 4, 20);
      drain();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      mismatched++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule